// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Aligner

This block sits between an instruction prefetch buffer and a decode stage. The prefetch side supplies 32-bit code words on a valid/ready stream, one word per accepted cycle, at consecutive word addresses. The block breaks each word into two 16-bit parcels and holds them in a short parcel queue. It reads the instruction length from the oldest parcel. When all of an instruction's parcels are present, it presents that instruction to decode as one left-aligned 48-bit field. An instruction may be one, two or three parcels long and may straddle two fetched words.

Along with the instruction, the block supplies its parcel count, its halfword program address and a 32-bit immediate. The immediate is taken from a 5-bit, 16-bit or 32-bit field, depending on the length. Short immediates are extended by zero or by sign, as a flag bit in the first parcel selects. A redirect input empties the queue and restarts the address at a target halfword. When the target is the odd parcel of a word, the block drops the first parcel of the next accepted word. The prefetcher must deliver words starting at the word that holds the target.

Top module: `vlen_fetch_aligner`

## Requirements
- R1: The length comes from bits [15:14] of the first parcel: 2'b11 gives 3 parcels (48 bits), 2'b10 gives 2 parcels (32 bits), and 2'b00 or 2'b01 gives 1 parcel (16 bits). `dec_len` carries the parcel count as 1, 2 or 3.
- R2: Bits [31:16] of a fetched word are the parcel at the lower halfword address and are consumed before bits [15:0].
- R3: `dec_valid` is high only when every parcel of the oldest instruction is held, including an instruction that spans two words. `dec_insn` holds the first parcel in [47:32], the second in [31:16] and the third in [15:0], and parcel slots beyond the length read as zero.
- R4: The immediate depends on the length. A 1-parcel instruction gives bits [4:0] of parcel one. A 2-parcel instruction gives parcel two. Both are sign-extended when bit 13 of parcel one is 1 and zero-extended when it is 0. A 3-parcel instruction gives parcel two in [31:16] and parcel three in [15:0].
- R5: With a word offered every cycle and decode always ready, a stream of 1-parcel instructions yields one instruction on every cycle after the first.
- R6: While `dec_valid` is high and `dec_ready` is low, the instruction and its address hold.
- R7: A redirect empties the queue. `fw_ready` is low during the redirect cycle, so the word offered then is not taken, and `dec_valid` is low in that cycle and in the next.
- R8: After a redirect, `dec_pc` equals the target halfword address. When bit 0 of the target is 1, bits [31:16] of the next accepted word are dropped.
- R9: `dec_pc` is a halfword address. It is 0 after reset and advances by `dec_len` when an instruction is taken.
- R10: After reset the queue is empty: `dec_valid` is 0 and `fw_ready` is 1.
- R11: `fw_ready` is low whenever more than DEPTH-2 parcels are held, so the queue never overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fw_valid | input | 1 | Fetched word is offered |
| fw_data | input | 32 | Fetched word, lower-address parcel in [31:16] |
| fw_ready | output | 1 | Aligner takes the offered word this cycle |
| redir_valid | input | 1 | Flush and restart at a new target |
| redir_hw | input | HW_ADDR_W | Target halfword address |
| dec_valid | output | 1 | Complete instruction available |
| dec_ready | input | 1 | Decode takes the instruction this cycle |
| dec_insn | output | 48 | Left-aligned instruction, unused parcels zero |
| dec_len | output | 2 | Parcel count 1, 2 or 3 |
| dec_imm | output | 32 | Extended immediate |
| dec_pc | output | HW_ADDR_W | Halfword address of the instruction |

## Verification
The assertions watch the following properties on every cycle:
- queue occupancy never underflows or overflows;
- a redirect blocks word intake and clears decode valid on the next cycle;
- a stalled instruction stays stable;
- the address steps by the length taken and loads the redirect target;
- a 48-bit instruction's immediate matches its trailing parcels.

Only the bench scenarios can show the remaining behaviour: that parcels from consecutive words are joined in the right order across word boundaries, and the extension rules. They also show the dropped parcel after an odd target and the sustained rate of one instruction per cycle.

// File: rtl/fa_pkg.sv
// Shared types and the length table of the fetch aligner.
// Assumes 16-bit parcels, two per fetched word, big-endian parcel order.
package fa_pkg;
    localparam int PARCEL_W  = 16;
    localparam int WORD_W    = 2 * PARCEL_W;
    localparam int INSN_W    = 3 * PARCEL_W;
    localparam int IMM_W     = 32;
    localparam int LEN_HI    = 15;   // length field is [LEN_HI:LEN_HI-1]
    localparam int SIGN_BIT  = 13;   // immediate extension select

    typedef logic [PARCEL_W-1:0] parcel_t;

    typedef enum logic [1:0] {
        LEN_P1 = 2'd1,
        LEN_P2 = 2'd2,
        LEN_P3 = 2'd3
    } ilen_e;

    // Parcel count from the first parcel of an instruction.
    function automatic ilen_e len_of(input parcel_t p);
        case (p[LEN_HI -: 2])
            2'b11:   return LEN_P3;
            2'b10:   return LEN_P2;
            default: return LEN_P1;
        endcase
    endfunction
endpackage

// File: rtl/fa_parcel_queue.sv
// Parcel queue: a shifting store of DEPTH parcels, slot 0 is the oldest.
// Each cycle it can drop 0..3 parcels from the head and append 0..2 at
// the tail. Assumes the caller never pops more than it holds and never
// pushes past DEPTH; DEPTH must be at least 4.
module fa_parcel_queue
    import fa_pkg::*;
#(
    parameter int DEPTH = 6,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [1:0]       pop_n,
    input  logic [1:0]       push_n,
    input  parcel_t          push_a,
    input  parcel_t          push_b,
    output parcel_t          head0,
    output parcel_t          head1,
    output parcel_t          head2,
    output logic [CNT_W-1:0] count
);
    parcel_t          q     [DEPTH];
    parcel_t          q_nxt [DEPTH];
    logic [CNT_W-1:0] count_nxt;

    // Shift out popped parcels and place pushed ones after the survivors.
    always_comb begin : next_slots
        int rem;
        int src;
        rem = int'(count) - int'(pop_n);
        for (int i = 0; i < DEPTH; i++) begin
            src      = i + int'(pop_n);
            q_nxt[i] = q[i];
            if (src < int'(count))
                q_nxt[i] = q[IDX_W'(src)];
            else if (i == rem && push_n != 2'd0)
                q_nxt[i] = push_a;
            else if (i == rem + 1 && push_n == 2'd2)
                q_nxt[i] = push_b;
        end
    end

    // Occupancy after this cycle's pop and push; a flush empties the queue.
    always_comb begin : next_count
        if (flush) count_nxt = '0;
        else       count_nxt = count - CNT_W'(pop_n) + CNT_W'(push_n);
    end

    // Register slots and occupancy.
    always_ff @(posedge clk) begin : store
        if (!rst_n) begin
            count <= '0;
            for (int i = 0; i < DEPTH; i++) q[i] <= '0;
        end else begin
            count <= count_nxt;
            for (int i = 0; i < DEPTH; i++) q[i] <= q_nxt[i];
        end
    end

    assign head0 = q[0];
    assign head1 = q[1];
    assign head2 = q[2];

    // R3
    underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        CNT_W'(pop_n) <= count);
    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |-> (int'(count) - int'(pop_n) + int'(push_n)) <= DEPTH);
    // R11
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
endmodule

// File: rtl/fa_insn_format.sv
// Instruction formatter: reads the length from the head parcel, assembles
// the left-aligned instruction with unused slots zeroed, and extracts and
// extends the immediate. Purely combinational; assumes the head parcels
// are valid whenever the caller uses the outputs.
module fa_insn_format
    import fa_pkg::*;
(
    input  parcel_t             h0,
    input  parcel_t             h1,
    input  parcel_t             h2,
    output logic [1:0]          len,
    output logic [INSN_W-1:0]   insn,
    output logic [IMM_W-1:0]    imm
);
    ilen_e l;
    logic  sx;

    assign l   = len_of(h0);
    assign len = l;
    assign sx  = h0[SIGN_BIT];

    // Place parcels behind the first one, zeroing slots past the length.
    always_comb begin : assemble
        insn = {h0, (l != LEN_P1) ? h1 : '0, (l == LEN_P3) ? h2 : '0};
    end

    // Pick the immediate field for the length and extend it.
    always_comb begin : extend_imm
        case (l)
            LEN_P3:  imm = {h1, h2};
            LEN_P2:  imm = {{(IMM_W-PARCEL_W){sx & h1[PARCEL_W-1]}}, h1};
            default: imm = {{(IMM_W-5){sx & h0[4]}}, h0[4:0]};
        endcase
    end
endmodule

// File: rtl/fa_flow_ctl.sv
// Flow control: tracks the halfword address of the head instruction and
// the pending odd-target skip, and splits an accepted word into parcels
// for the queue. Assumes the caller blocks word intake while redirecting.
module fa_flow_ctl
    import fa_pkg::*;
#(
    parameter int HW_ADDR_W = 31
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 redir_valid,
    input  logic [HW_ADDR_W-1:0] redir_hw,
    input  logic                 accept,
    input  logic                 fire,
    input  logic [1:0]           fire_len,
    input  logic [WORD_W-1:0]    fw_data,
    output logic [HW_ADDR_W-1:0] pc,
    output logic [1:0]           push_n,
    output parcel_t              push_a,
    output parcel_t              push_b
);
    logic skip_odd;

    // Load the target on redirect, otherwise step past taken instructions.
    always_ff @(posedge clk) begin : addr_track
        if (!rst_n) begin
            pc       <= '0;
            skip_odd <= 1'b0;
        end else if (redir_valid) begin
            pc       <= redir_hw;
            skip_odd <= redir_hw[0];
        end else begin
            if (fire)   pc       <= pc + HW_ADDR_W'(fire_len);
            if (accept) skip_odd <= 1'b0;
        end
    end

    // Split the word; after an odd target only the low parcel is kept.
    always_comb begin : split_word
        push_b = fw_data[PARCEL_W-1:0];
        push_a = skip_odd ? fw_data[PARCEL_W-1:0] : fw_data[WORD_W-1:PARCEL_W];
        if (!accept)       push_n = 2'd0;
        else if (skip_odd) push_n = 2'd1;
        else               push_n = 2'd2;
    end

    // R8
    redirect_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> pc == $past(redir_hw));
    // R9
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !redir_valid) |=> pc == $past(pc) + HW_ADDR_W'($past(fire_len)));
endmodule

// File: rtl/vlen_fetch_aligner.sv
// Variable-length fetch aligner top. Takes 32-bit code words, queues them
// as parcels, and hands decode one complete 16/32/48-bit instruction per
// cycle with its length, halfword address and extended immediate.
// Assumes the prefetcher restarts at the word holding a redirect target.
module vlen_fetch_aligner
    import fa_pkg::*;
#(
    parameter int HW_ADDR_W = 31,
    parameter int DEPTH     = 6,
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fw_valid,
    input  logic [31:0]          fw_data,
    output logic                 fw_ready,
    input  logic                 redir_valid,
    input  logic [HW_ADDR_W-1:0] redir_hw,
    output logic                 dec_valid,
    input  logic                 dec_ready,
    output logic [47:0]          dec_insn,
    output logic [1:0]           dec_len,
    output logic [31:0]          dec_imm,
    output logic [HW_ADDR_W-1:0] dec_pc
);
    parcel_t          h0, h1, h2, push_a, push_b;
    logic [CNT_W-1:0] count;
    logic [1:0]       push_n, pop_n;
    logic             accept, fire;

    // Intake and hand-off conditions.
    always_comb begin : handshake
        fw_ready  = !redir_valid && (count <= CNT_W'(DEPTH - 2));
        accept    = fw_valid && fw_ready;
        dec_valid = !redir_valid && (count >= CNT_W'(dec_len));
        fire      = dec_valid && dec_ready;
        pop_n     = fire ? dec_len : 2'd0;
    end

    fa_parcel_queue #(.DEPTH(DEPTH)) u_queue (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (redir_valid),
        .pop_n  (pop_n),
        .push_n (push_n),
        .push_a (push_a),
        .push_b (push_b),
        .head0  (h0),
        .head1  (h1),
        .head2  (h2),
        .count  (count)
    );

    fa_insn_format u_format (
        .h0   (h0),
        .h1   (h1),
        .h2   (h2),
        .len  (dec_len),
        .insn (dec_insn),
        .imm  (dec_imm)
    );

    fa_flow_ctl #(.HW_ADDR_W(HW_ADDR_W)) u_flow (
        .clk         (clk),
        .rst_n       (rst_n),
        .redir_valid (redir_valid),
        .redir_hw    (redir_hw),
        .accept      (accept),
        .fire        (fire),
        .fire_len    (dec_len),
        .fw_data     (fw_data),
        .pc          (dec_pc),
        .push_n      (push_n),
        .push_a      (push_a),
        .push_b      (push_b)
    );

    // R7
    redirect_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> !dec_valid);
    // R7
    ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> !fw_ready);
    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_ready) |=>
            (redir_valid || (dec_valid && $stable(dec_insn) && $stable(dec_pc))));
    // R1
    len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> dec_len != 2'd0);
    // R4
    wide_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_len == 2'd3) |-> dec_imm == dec_insn[31:0]);
endmodule

// File: tb/tb_vlen_fetch_aligner.sv
`timescale 1ns/1ps
module tb_vlen_fetch_aligner;
    localparam int AW = 31;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fw_valid = 1'b0;
    logic [31:0]   fw_data = '0;
    logic          fw_ready;
    logic          redir_valid = 1'b0;
    logic [AW-1:0] redir_hw = '0;
    logic          dec_valid;
    logic          dec_ready = 1'b0;
    logic [47:0]   dec_insn;
    logic [1:0]    dec_len;
    logic [31:0]   dec_imm;
    logic [AW-1:0] dec_pc;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    vlen_fetch_aligner #(.HW_ADDR_W(AW), .DEPTH(6)) dut (.*);

    // Stream table: fetched words and the instructions expected from them.
    localparam int NW = 9;
    localparam int NI = 11;
    localparam logic [31:0] WORDS [NW] = '{
        32'h0005201F, 32'h80001234, 32'hA0008001, 32'hC000DEAD, 32'hBEEF0003,
        32'h0011C000, 32'h00000001, 32'h00028ABC, 32'h7FFF0004};
    localparam logic [47:0] EXP_INSN [NI] = '{
        48'h0005_0000_0000, 48'h201F_0000_0000, 48'h8000_1234_0000,
        48'hA000_8001_0000, 48'hC000_DEAD_BEEF, 48'h0003_0000_0000,
        48'h0011_0000_0000, 48'hC000_0000_0001, 48'h0002_0000_0000,
        48'h8ABC_7FFF_0000, 48'h0004_0000_0000};
    localparam logic [1:0] EXP_LEN [NI] = '{
        2'd1, 2'd1, 2'd2, 2'd2, 2'd3, 2'd1, 2'd1, 2'd3, 2'd1, 2'd2, 2'd1};
    localparam logic [31:0] EXP_IMM [NI] = '{
        32'h5, 32'hFFFFFFFF, 32'h1234, 32'hFFFF8001, 32'hDEADBEEF, 32'h3,
        32'h11, 32'h1, 32'h2, 32'h7FFF, 32'h4};
    localparam logic [AW-1:0] EXP_PC [NI] = '{
        31'h0, 31'h1, 31'h2, 31'h4, 31'h6, 31'h9, 31'hA, 31'hB, 31'hE,
        31'hF, 31'h11};

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic redirect(input logic [AW-1:0] tgt);
        redir_valid = 1'b1;
        redir_hw    = tgt;
        fw_valid    = 1'b0;
        @(negedge clk);
        redir_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        int kw, ki, nvalid;
        bit acc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10 reset state
        chk(dec_valid == 1'b0, "R10 dec_valid after reset", 64'(dec_valid), 0);
        chk(fw_ready == 1'b1, "R10 fw_ready after reset", 64'(fw_ready), 1);
        chk(dec_pc == '0, "R9 pc after reset", 64'(dec_pc), 0);

        // R11 backpressure and R6 stall
        @(negedge clk);
        dec_ready = 1'b0;
        fw_valid  = 1'b1;
        fw_data   = 32'h00010002;
        repeat (3) @(negedge clk);
        #1;
        chk(fw_ready == 1'b0, "R11 fw_ready low when full", 64'(fw_ready), 0);
        chk(dec_valid && dec_insn == 48'h0001_0000_0000, "R6 head while stalled",
            64'(dec_insn), 64'h0001_0000_0000);
        repeat (2) @(negedge clk);
        #1;
        chk(dec_valid && dec_insn == 48'h0001_0000_0000 && dec_pc == '0,
            "R6 held under stall", 64'(dec_insn), 64'h0001_0000_0000);

        // R7 redirect while full, with a word offered
        @(negedge clk);
        redir_valid = 1'b1;
        redir_hw    = 31'h81;
        fw_valid    = 1'b1;
        #1;
        chk(fw_ready == 1'b0, "R7 no intake during redirect", 64'(fw_ready), 0);
        chk(dec_valid == 1'b0, "R7 no decode during redirect", 64'(dec_valid), 0);
        @(negedge clk);
        redir_valid = 1'b0;
        fw_valid    = 1'b0;
        #1;
        chk(dec_valid == 1'b0, "R7 queue flushed", 64'(dec_valid), 0);
        chk(dec_pc == 31'h81, "R8 pc loads target", 64'(dec_pc), 64'h81);

        // R8 odd target drops the high parcel of the first word
        @(negedge clk);
        dec_ready = 1'b1;
        fw_valid  = 1'b1;
        fw_data   = 32'hFFFF0007;
        @(negedge clk);
        fw_data = 32'h0009000A;
        #1;
        chk(dec_valid && dec_insn == 48'h0007_0000_0000, "R8 odd target insn",
            64'(dec_insn), 64'h0007_0000_0000);
        chk(dec_pc == 31'h81, "R8 odd target pc", 64'(dec_pc), 64'h81);
        @(negedge clk);
        fw_valid = 1'b0;
        #1;
        chk(dec_valid && dec_insn == 48'h0009_0000_0000 && dec_pc == 31'h82,
            "R2 high parcel first", 64'(dec_insn), 64'h0009_0000_0000);
        @(negedge clk);
        #1;
        chk(dec_valid && dec_insn == 48'h000A_0000_0000 && dec_pc == 31'h83,
            "R2 low parcel second", 64'(dec_insn), 64'h000A_0000_0000);

        // R3 partial 48-bit instruction is not presented
        @(negedge clk);
        redirect('0);
        fw_valid = 1'b1;
        fw_data  = 32'hC000DEAD;
        @(negedge clk);
        fw_valid = 1'b0;
        #1;
        chk(dec_valid == 1'b0, "R3 two of three parcels", 64'(dec_valid), 0);
        @(negedge clk);
        fw_valid = 1'b1;
        fw_data  = 32'hBEEF0003;
        #1;
        chk(dec_valid == 1'b0, "R3 still incomplete", 64'(dec_valid), 0);
        @(negedge clk);
        fw_valid = 1'b0;
        #1;
        chk(dec_valid && dec_insn == 48'hC000_DEAD_BEEF && dec_len == 2'd3,
            "R3 spanning insn complete", 64'(dec_insn), 64'hC000_DEAD_BEEF);

        // Table walk: R1 R3 R4 R9 over a mixed stream
        @(negedge clk);
        redirect('0);
        kw = 0;
        ki = 0;
        for (int cyc = 0; cyc < 80 && ki < NI; cyc++) begin
            fw_valid  = (kw < NW);
            fw_data   = (kw < NW) ? WORDS[kw] : 32'h0;
            dec_ready = 1'b1;
            #1;
            acc = fw_valid && fw_ready;
            if (dec_valid) begin
                chk(dec_insn == EXP_INSN[ki], $sformatf("R3 insn %0d", ki),
                    64'(dec_insn), 64'(EXP_INSN[ki]));
                chk(dec_len == EXP_LEN[ki], $sformatf("R1 len %0d", ki),
                    64'(dec_len), 64'(EXP_LEN[ki]));
                chk(dec_imm == EXP_IMM[ki], $sformatf("R4 imm %0d", ki),
                    64'(dec_imm), 64'(EXP_IMM[ki]));
                chk(dec_pc == EXP_PC[ki], $sformatf("R9 pc %0d", ki),
                    64'(dec_pc), 64'(EXP_PC[ki]));
                ki++;
            end
            @(negedge clk);
            if (acc) kw++;
        end
        fw_valid = 1'b0;
        chk(ki == NI, "R3 all table insns delivered", 64'(ki), 64'(NI));

        // R5 one 16-bit instruction per cycle
        @(negedge clk);
        redirect(31'h100);
        fw_valid  = 1'b1;
        fw_data   = 32'h00010001;
        dec_ready = 1'b1;
        nvalid    = 0;
        for (int c = 0; c < 16; c++) begin
            #1;
            if (dec_valid) nvalid++;
            @(negedge clk);
        end
        chk(nvalid == 15, "R5 sustained rate", 64'(nvalid), 15);

        // R10 reset while busy
        rst_n    = 1'b0;
        fw_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(dec_valid == 1'b0 && fw_ready == 1'b1, "R10 reset clears queue",
            64'(dec_valid), 0);
        chk(dec_pc == '0, "R9 reset clears pc", 64'(dec_pc), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule